// File: doc/BRIEF.md
# Timer Slave-Mode Counter Controller

This block governs a general-purpose timer's counter from a single selected trigger. A 3-bit source selector picks one of eight candidate trigger lines: four internal trigger lines from neighbouring timers, a channel-1 transition pulse, the two filtered channel levels and a filtered external trigger. A 3-bit mode field then decides how the selected trigger, or the two channel inputs, move the counter. The eight modes are free running, three quadrature-encoder variants, restart on trigger, level gating, start on trigger and counting trigger edges.

A synchronisation bit holds back the trigger's effect on this counter by one clock. The rising-edge pulse sent out to linked timers stays undelayed, so that a chain of timers can react to one shared event in the same cycle. The counter wraps at a run-time reload limit, and every wrap or restart raises a one-cycle update pulse.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count is 0, the direction flag is 0 (up) and the update pulse is 0.
- R2: The source selector maps as follows: 0 to 3 select internal lines 0 to 3, 4 selects the channel-1 transition pulse, 5 selects filtered channel 1, 6 selects filtered channel 2 and 7 selects the external trigger. The trigger output is high, combinationally, exactly when the selected source is high and was low at the previous clock edge, whatever the synchronisation bit.
- R3: Mode 0 (free run): at each clock edge with the enable high, the count steps up. A step from a count at or above the reload value goes to 0 instead and raises the update pulse for one cycle.
- R4: Mode 1: the counter moves only when channel 2 changes. It steps up when the new channel-2 level equals channel 1 and steps down otherwise.
- R5: Mode 2: the counter moves only when channel 1 changes. It steps up when the new channel-1 level differs from channel 2 and steps down otherwise.
- R6: Mode 3: a change on exactly one channel moves the counter by the rule of R4 or R5 for that channel. If both channels change in the same cycle, nothing moves.
- R7: Encoder steps need the enable. An up step from the reload value wraps to 0 and a down step from 0 wraps to the reload value, each with an update pulse. The direction flag (1 = down) shows the last encoder step, and any other up step clears it.
- R8: Mode 4 (restart): a trigger rising edge sets the count to 0 and raises the update pulse, taking priority over the free-running up step that the enable otherwise gives.
- R9: Mode 5 (gated): the count steps up only while the enable and the trigger level are both high, and holds otherwise. With source 4 selected the gate stays closed and the count holds.
- R10: Mode 6 (start): a trigger rising edge latches a run flag, and from the next edge on the count steps up every cycle, even with the enable low. The flag clears when the mode leaves 6.
- R11: Mode 7 (edge count): with the enable high, each trigger rising edge steps the count up once.
- R12: With the synchronisation bit set, the trigger level and rising edge that drive the modes are the selected source one clock later. The trigger output is not delayed.
- R13: With the enable low, modes 0, 1, 2, 3, 4, 5 and 7 leave the count unchanged, except that a restart in mode 4 still clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| itrig_i | input | 4 | Internal trigger lines 0 to 3 |
| ch1_edge_i | input | 1 | Channel-1 transition pulse |
| ch1_i | input | 1 | Filtered channel-1 level |
| ch2_i | input | 1 | Filtered channel-2 level |
| ext_trig_i | input | 1 | Filtered external trigger |
| cnt_en_i | input | 1 | Counter enable |
| src_sel_i | input | 3 | Trigger source selector |
| mode_i | input | 3 | Slave mode |
| sync_i | input | 1 | Delay the trigger's effect by one clock |
| reload_i | input | CNT_W | Wrap limit of the counter |
| count_o | output | CNT_W | Counter value |
| dir_down_o | output | 1 | Direction of the last step, 1 = down |
| update_o | output | 1 | One-cycle pulse on wrap or restart |
| trig_out_o | output | 1 | Undelayed rising-edge pulse of the selected trigger |

## Verification
The count, direction and update outputs are registered. Inputs driven after a falling edge therefore show up in them after the next rising edge, or one edge later when the synchronisation bit is set. The trigger output depends combinationally on the present source level and the previous edge's sample. The bench drives inputs just after each falling edge. It checks the trigger output a nanosecond later against its reference model, and checks the registered outputs at the following falling edge. The model advances once per rising edge from the same input values, so every delay appears in it as its own state, and no check has to wait a hand-counted number of cycles.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;
  typedef enum logic [2:0] {
    MODE_FREE  = 3'd0,
    MODE_ENC2  = 3'd1,
    MODE_ENC1  = 3'd2,
    MODE_ENC12 = 3'd3,
    MODE_RESTART = 3'd4,
    MODE_GATE  = 3'd5,
    MODE_START = 3'd6,
    MODE_EXTCK = 3'd7
  } slave_mode_e;

  localparam logic [2:0] SRC_CH1_EDGE = 3'd4;
endpackage

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel #(
  parameter int N_ITR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ITR-1:0] itrig_i,
  input  logic             ch1_edge_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic             ext_trig_i,
  input  logic [2:0]       src_sel_i,
  input  logic             sync_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             trig_out_o
);
  localparam int N_SRC = N_ITR + 4;

  logic [N_SRC-1:0] src_vec;
  logic             raw;
  logic             raw_q, raw_qq;

  assign src_vec = {ext_trig_i, ch2_i, ch1_i, ch1_edge_i, itrig_i};
  assign raw     = src_vec[src_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      raw_qq <= 1'b0;
    end else begin
      raw_q  <= raw;
      raw_qq <= raw_q;
    end
  end

  assign trig_out_o = raw & ~raw_q;
  assign lvl_o      = sync_i ? raw_q : raw;
  assign rise_o     = sync_i ? (raw_q & ~raw_qq) : trig_out_o;

  // R2: a pulse on the output is followed by the source sampled high
  p_trig_out_sampled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_out_o |=> raw_q);
  // R12: a delayed edge reflects the output pulse of one cycle earlier
  p_sync_edge_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && $past(sync_i) && rise_o) |-> $past(trig_out_o));
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec
  import tmr_slave_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ch1_i,
  input  logic        ch2_i,
  input  slave_mode_e mode_i,
  output logic        up_o,
  output logic        dn_o
);
  logic ch1_q, ch2_q;
  logic e1, e2;
  logic up1, dn1, up2, dn2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch1_q <= 1'b0;
      ch2_q <= 1'b0;
    end else begin
      ch1_q <= ch1_i;
      ch2_q <= ch2_i;
    end
  end

  assign e1  = ch1_i ^ ch1_q;
  assign e2  = ch2_i ^ ch2_q;
  assign up1 = e1 & (ch1_i != ch2_i);
  assign dn1 = e1 & (ch1_i == ch2_i);
  assign up2 = e2 & (ch2_i == ch1_i);
  assign dn2 = e2 & (ch2_i != ch1_i);

  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    unique case (mode_i)
      MODE_ENC2:  begin up_o = up2; dn_o = dn2; end
      MODE_ENC1:  begin up_o = up1; dn_o = dn1; end
      MODE_ENC12: begin
        up_o = (e1 ^ e2) & (up1 | up2);
        dn_o = (e1 ^ e2) & (dn1 | dn2);
      end
      default: ;
    endcase
  end

  // R6: never both directions at once
  p_enc_one_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_o, dn_o}));
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_down_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             upd_q, upd_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    upd_d = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
      upd_d = 1'b1;
    end else if (up_i) begin
      dir_d = 1'b0;
      if (cnt_q >= reload_i) begin
        cnt_d = '0;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (dn_i) begin
      dir_d = 1'b1;
      if (cnt_q == '0) begin
        cnt_d = reload_i;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      upd_q <= upd_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;
  assign upd_o      = upd_q;

  // R8: a restart clears the count and flags an update
  p_restart_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0) && upd_q);
  // R7: a down step from zero lands on the reload value
  p_down_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !clear_i && !up_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)) && dir_q);
  // R13: no request leaves the count alone
  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_i || up_i || dn_i) |=> $stable(cnt_q) && !upd_q);
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_ITR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ITR-1:0] itrig_i,
  input  logic             ch1_edge_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic             ext_trig_i,
  input  logic             cnt_en_i,
  input  logic [2:0]       src_sel_i,
  input  logic [2:0]       mode_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             update_o,
  output logic             trig_out_o
);
  slave_mode_e mode;
  logic lvl, rise;
  logic enc_up, enc_dn;
  logic run_q, run_d;
  logic up, dn, clr;

  assign mode = slave_mode_e'(mode_i);

  tmr_trig_sel #(.N_ITR(N_ITR)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .itrig_i    (itrig_i),
    .ch1_edge_i (ch1_edge_i),
    .ch1_i      (ch1_i),
    .ch2_i      (ch2_i),
    .ext_trig_i (ext_trig_i),
    .src_sel_i  (src_sel_i),
    .sync_i     (sync_i),
    .lvl_o      (lvl),
    .rise_o     (rise),
    .trig_out_o (trig_out_o)
  );

  tmr_quad_dec u_quad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ch1_i  (ch1_i),
    .ch2_i  (ch2_i),
    .mode_i (mode),
    .up_o   (enc_up),
    .dn_o   (enc_dn)
  );

  always_comb begin
    run_d = (mode == MODE_START) ? (run_q | rise) : 1'b0;
    up    = 1'b0;
    dn    = 1'b0;
    clr   = 1'b0;
    unique case (mode)
      MODE_FREE:    up = cnt_en_i;
      MODE_ENC2,
      MODE_ENC1,
      MODE_ENC12: begin
        up = cnt_en_i & enc_up;
        dn = cnt_en_i & enc_dn;
      end
      MODE_RESTART: begin
        clr = rise;
        up  = cnt_en_i;
      end
      MODE_GATE:    up = cnt_en_i & lvl & (src_sel_i != SRC_CH1_EDGE);
      MODE_START:   up = cnt_en_i | run_q;
      MODE_EXTCK:   up = cnt_en_i & rise;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  tmr_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clr),
    .up_i       (up),
    .dn_i       (dn),
    .reload_i   (reload_i),
    .cnt_o      (count_o),
    .dir_down_o (dir_down_o),
    .upd_o      (update_o)
  );

  // R9: a closed gate holds the count
  p_gate_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GATE && (!lvl || src_sel_i == SRC_CH1_EDGE)) |=> $stable(count_o));
  // R10: once started, the count keeps moving while the mode stays
  p_start_runs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_START && run_q) |=> (count_o != $past(count_o)) || update_o);
  // R3: free-run wrap at the limit
  p_free_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_FREE && cnt_en_i && count_o >= reload_i) |=> (count_o == '0) && update_o);
endmodule

// File: tb/tmr_slave_ctrl_tb_top.sv
`timescale 1ns/1ps
module tmr_slave_ctrl_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       itrig;
  logic             ch1_edge, ch1, ch2, ext_trig, cnt_en, sync;
  logic [2:0]       src_sel, mode;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             dir_down, update, trig_out;

  int checks = 0;
  int failures = 0;

  // reference model state
  int m_cnt, m_dir, m_upd, m_rq, m_rqq, m_a, m_b, m_run;

  always #2 clk = ~clk;

  tmr_slave_ctrl #(.CNT_W(CNT_W), .N_ITR(4)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .itrig_i    (itrig),
    .ch1_edge_i (ch1_edge),
    .ch1_i      (ch1),
    .ch2_i      (ch2),
    .ext_trig_i (ext_trig),
    .cnt_en_i   (cnt_en),
    .src_sel_i  (src_sel),
    .mode_i     (mode),
    .sync_i     (sync),
    .reload_i   (reload),
    .count_o    (count),
    .dir_down_o (dir_down),
    .update_o   (update),
    .trig_out_o (trig_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int src_level();
    case (src_sel)
      3'd0: return itrig[0];
      3'd1: return itrig[1];
      3'd2: return itrig[2];
      3'd3: return itrig[3];
      3'd4: return ch1_edge;
      3'd5: return ch1;
      3'd6: return ch2;
      default: return ext_trig;
    endcase
  endfunction

  // Inputs are already driven (just after a falling edge). Check, advance model, check.
  task automatic tick(input string req);
    int raw, rise, lvl, ea, eb, up, dn, clr;
    #1;
    raw = src_level();
    check("R2", "trig_out", int'(trig_out), (raw == 1 && m_rq == 0) ? 1 : 0);
    rise = sync ? (m_rq & ~m_rqq & 1) : (raw & ~m_rq & 1);
    lvl  = sync ? m_rq : raw;
    ea = (ch1 != m_a); eb = (ch2 != m_b);
    up = 0; dn = 0; clr = 0;
    case (mode)
      3'd0: up = cnt_en;
      3'd1: if (cnt_en && eb) begin if (ch2 == ch1) up = 1; else dn = 1; end
      3'd2: if (cnt_en && ea) begin if (ch1 != ch2) up = 1; else dn = 1; end
      3'd3: if (cnt_en && (ea != eb)) begin
              if (ea) begin if (ch1 != ch2) up = 1; else dn = 1; end
              else    begin if (ch2 == ch1) up = 1; else dn = 1; end
            end
      3'd4: begin clr = rise; up = cnt_en; end
      3'd5: up = cnt_en && lvl && src_sel != 3'd4;
      3'd6: up = cnt_en || m_run;
      default: up = cnt_en && rise;
    endcase
    m_upd = 0;
    if (clr) begin m_cnt = 0; m_upd = 1; end
    else if (up) begin
      m_dir = 0;
      if (m_cnt >= int'(reload)) begin m_cnt = 0; m_upd = 1; end else m_cnt++;
    end else if (dn) begin
      m_dir = 1;
      if (m_cnt == 0) begin m_cnt = int'(reload); m_upd = 1; end else m_cnt--;
    end
    m_run = (mode == 3'd6) ? (m_run | rise) : 0;
    m_rqq = m_rq; m_rq = raw; m_a = ch1; m_b = ch2;
    @(negedge clk);
    check(req, "count", int'(count), m_cnt);
    check(req, "dir_down", int'(dir_down), m_dir);
    check(req, "update", int'(update), m_upd);
  endtask

  task automatic set_cfg(input int md, input int sel, input int en, input int sy, input int rl);
    // the selector only moves while the mode is free-run
    mode = 3'd0; cnt_en = 1'b0; tick("R13");
    src_sel = 3'(sel); tick("R13");
    mode = 3'(md); cnt_en = en[0]; sync = sy[0]; reload = CNT_W'(rl);
  endtask

  task automatic drive_src(input int sel, input logic v);
    case (sel)
      0, 1, 2, 3: itrig[sel] = v;
      4: ch1_edge = v;
      5: ch1 = v;
      6: ch2 = v;
      default: ext_trig = v;
    endcase
  endtask

  task automatic quad(input string req, input int md, input int steps, input int fwd);
    int ph;
    ph = 0;
    for (int i = 0; i < steps; i++) begin
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      ch1 = (ph == 1 || ph == 2);
      ch2 = (ph == 2 || ph == 3);
      tick(req);
      tick(req);
    end
  endtask

  initial begin
    #(4ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    itrig = '0; ch1_edge = 0; ch1 = 0; ch2 = 0; ext_trig = 0;
    cnt_en = 0; sync = 0; src_sel = '0; mode = '0; reload = 16'd9;
    m_cnt = 0; m_dir = 0; m_upd = 0; m_rq = 0; m_rqq = 0; m_a = 0; m_b = 0; m_run = 0;
    repeat (3) @(negedge clk);
    check("R1", "count", int'(count), 0);
    check("R1", "dir_down", int'(dir_down), 0);
    check("R1", "update", int'(update), 0);
    rst_n = 1'b1;
    tick("R1");

    // R3: free run with wrap at 9, then R13 with the enable low
    cnt_en = 1;
    for (int i = 0; i < 25; i++) tick("R3");
    cnt_en = 0;
    for (int i = 0; i < 6; i++) tick("R13");

    // R11 and R2: edge counting on every source
    for (int s = 0; s < 8; s++) begin
      set_cfg(7, s, 1, 0, 1000);
      for (int i = 0; i < 12; i++) begin drive_src(s, (i % 3) == 0); tick("R11"); end
      drive_src(s, 1'b0);
    end

    // R8: restart on internal line 3, with the enable high then low
    set_cfg(4, 3, 1, 0, 100);
    for (int i = 0; i < 30; i++) begin itrig[3] = (i % 7) == 5; tick("R8"); end
    cnt_en = 0;
    for (int i = 0; i < 10; i++) begin itrig[3] = (i % 4) == 1; tick("R13"); end
    itrig[3] = 0;

    // R9: gating on channel 1, then the forbidden transition-pulse source
    set_cfg(5, 5, 1, 0, 100);
    for (int i = 0; i < 24; i++) begin ch1 = ((i / 4) % 2) == 1; tick("R9"); end
    ch1 = 0;
    set_cfg(5, 4, 1, 0, 100);
    for (int i = 0; i < 12; i++) begin ch1_edge = ~ch1_edge; tick("R9"); end
    ch1_edge = 0;

    // R10: start on the external trigger with the enable low
    set_cfg(6, 7, 0, 0, 15);
    for (int i = 0; i < 5; i++) tick("R10");
    ext_trig = 1; tick("R10");
    ext_trig = 0;
    for (int i = 0; i < 25; i++) tick("R10");

    // R12: delayed trigger in edge counting and restart modes
    set_cfg(7, 1, 1, 1, 1000);
    for (int i = 0; i < 14; i++) begin itrig[1] = (i % 4) < 2; tick("R12"); end
    itrig[1] = 0;
    set_cfg(4, 2, 1, 1, 100);
    for (int i = 0; i < 20; i++) begin itrig[2] = (i % 6) == 3; tick("R12"); end
    itrig[2] = 0;
    sync = 0;

    // R4, R5, R6, R7: quadrature in both directions across the wrap points
    set_cfg(1, 0, 1, 0, 5);
    quad("R4", 1, 12, 1); quad("R4", 1, 16, 0);
    ch1 = 0; ch2 = 0; tick("R4");
    set_cfg(2, 0, 1, 0, 5);
    quad("R5", 2, 12, 1); quad("R5", 2, 16, 0);
    ch1 = 0; ch2 = 0; tick("R5");
    set_cfg(3, 0, 1, 0, 5);
    quad("R7", 3, 14, 1); quad("R7", 3, 20, 0);
    ch1 = 0; ch2 = 0; tick("R6");
    ch1 = 1; ch2 = 1; tick("R6");
    ch1 = 0; tick("R6");
    ch1 = 1; ch2 = 0; tick("R6");
    cnt_en = 0; ch2 = 1; tick("R13");
    ch1 = 0; tick("R13");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule